// File: doc/BRIEF.md
# Buck Converter Light-Load Mode Selector

This block is the digital mode logic for one channel of a synchronous step-down controller. It decides whether the channel runs as a fixed-frequency PWM converter in continuous conduction, or as a hysteretic converter whose low-side switch behaves like a diode. Once per switching period, a strobe marks the moment to read a comparator bit. That bit reports the polarity of the switch node while the high-side switch is off.

A negative switch node means the inductor current is still flowing forward, so the load is heavy and PWM suits it. A positive switch node means the current is heading toward reversal, so hysteretic mode suits it. The selector changes mode only after a fixed run of consecutive samples all call for the other mode. The same rule applies in both directions, which keeps the channel from chattering near the boundary.

A strap input pins the channel to PWM. In hysteretic mode the low-side drive request is cut as soon as reverse current shows. It then stays cut until the next high-side pulse.

Top module: `buck_mode_ctrl`

## Requirements
- R1: After a clock edge with `rst_n` low, `mode_hys_o` is 0 (PWM) and the run counter is empty. From reset, exactly `RUN_LEN` qualifying samples are needed to leave PWM.
- R2: While `force_pwm_i` is 1, `mode_hys_o` is 0 from the next clock edge on, and samples have no effect on the mode. The run counter is emptied.
- R3: A sample counts only in a cycle where `smp_stb_i` is 1, `hs_req_i` is 0 and `force_pwm_i` is 0. A strobe while `hs_req_i` is 1 leaves the mode and the run unchanged.
- R4: Encoding: `phase_neg_i` = 1 votes for PWM (`mode_hys_o` = 0), and `phase_neg_i` = 0 votes for hysteretic (`mode_hys_o` = 1).
- R5: From PWM, the mode becomes hysteretic on the clock edge that registers the 8th (`RUN_LEN`) consecutive counted sample with `phase_neg_i` = 0. After 7 such samples it is still PWM. At that edge the run counter empties.
- R6: A counted sample that votes for the current mode empties the run counter, so a fresh full run is needed afterwards.
- R7: From hysteretic, the mode returns to PWM after 8 consecutive counted samples with `phase_neg_i` = 1, under the same rules as R5 and R6.
- R8: `ls_drv_o` is never 1 while `hs_req_i` is 1.
- R9: In PWM mode with `hs_req_i` = 0, `ls_drv_o` equals `ls_req_i` in the same cycle.
- R10: In hysteretic mode, `ls_drv_o` goes to 0 in the same cycle as `ls_req_i` = 1 with `phase_neg_i` = 0. It then stays 0 until a cycle with `hs_req_i` = 1 has passed, even if `phase_neg_i` returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| force_pwm_i | input | 1 | Strap: hold the channel in PWM mode |
| smp_stb_i | input | 1 | One-cycle strobe per switching period marking the polarity sample point |
| phase_neg_i | input | 1 | Switch-node polarity comparator, 1 = negative |
| hs_req_i | input | 1 | High-side drive request from the modulator |
| ls_req_i | input | 1 | Low-side drive request from the modulator |
| mode_hys_o | output | 1 | Current mode, 0 = PWM, 1 = hysteretic |
| ls_drv_o | output | 1 | Gated low-side drive command |

## Verification
The assertions assume that every input is synchronous to `clk`. They also assume the strobe is a single cycle, with the polarity bit settled in that cycle. Nothing beyond that is assumed about how the modulator sequences its requests, so overlapping high-side and low-side requests are legal input and must still be blocked at the output. The stimulus changes inputs only on the falling edge. Its random part biases the polarity into long runs that occasionally flip, so that full eight-sample runs and broken runs both occur. The strap and high-side-time strobes are injected rarely enough that they interrupt runs instead of suppressing them.

// File: rtl/buck_mode_pkg.sv
// Package: shared types for the buck mode selector.
// Assumes: one channel per instance; mode encoded in one bit.
package buck_mode_pkg;
    typedef enum logic {
        MODE_PWM = 1'b0,
        MODE_HYS = 1'b1
    } mode_e;
endpackage

// File: rtl/bm_sample_qual.sv
// Module: bm_sample_qual
// Turns the raw strobe and polarity bit into a qualified vote.
// Assumes: strobe is one cycle wide, polarity settled in that cycle.
module bm_sample_qual (
    input  logic force_i,
    input  logic stb_i,
    input  logic hs_req_i,
    input  logic phase_neg_i,
    output logic valid_o,
    output logic want_hys_o
);
    // Qualify the sample to the off period with automatic mode enabled (R3) and decode the vote (R4).
    always_comb begin
        valid_o    = stb_i & ~hs_req_i & ~force_i;
        want_hys_o = ~phase_neg_i;
    end
endmodule

// File: rtl/bm_run_filter.sv
// Module: bm_run_filter
// Holds the mode and counts consecutive opposing votes; toggles the
// mode when the run reaches RUN_LEN and empties the run on a match.
// Assumes: valid_i already excludes forced and high-side cycles.
module bm_run_filter
    import buck_mode_pkg::*;
#(
    parameter int RUN_LEN = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  force_i,
    input  logic  valid_i,
    input  logic  want_hys_i,
    output mode_e mode_o
);
    localparam int CNT_W = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RUN_LEN - 1);

    logic [CNT_W-1:0] cnt_q;
    mode_e            mode_q;
    logic             opposing;
    logic             run_done;

    // Flag a vote against the current mode and the terminal count.
    always_comb begin
        opposing = valid_i & (want_hys_i != (mode_q == MODE_HYS));
        run_done = opposing & (cnt_q == CNT_LAST);
    end

    // Mode register and run counter with strap override (R1, R2, R5, R6, R7).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_PWM;
            cnt_q  <= '0;
        end else if (force_i) begin
            mode_q <= MODE_PWM;
            cnt_q  <= '0;
        end else if (run_done) begin
            mode_q <= (mode_q == MODE_HYS) ? MODE_PWM : MODE_HYS;
            cnt_q  <= '0;
        end else if (opposing) begin
            cnt_q  <= cnt_q + CNT_W'(1);
        end else if (valid_i) begin
            cnt_q  <= '0;
        end
    end

    assign mode_o = mode_q;

    // Strap pins PWM from the next edge (R2).
    assert_force_pwm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        force_i |=> (mode_q == MODE_PWM));

    // No counted sample, no mode change (R3).
    assert_hold_without_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_i && !valid_i) |=> $stable(mode_q));

    // Completed run flips the mode and empties the run (R5, R7).
    assert_toggle_on_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_i && valid_i && (want_hys_i != (mode_q == MODE_HYS)) && cnt_q == CNT_LAST)
        |=> (mode_q != $past(mode_q)) && (cnt_q == '0));

    // Agreeing vote keeps the mode and empties the run (R6).
    assert_match_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_i && valid_i && (want_hys_i == (mode_q == MODE_HYS)))
        |=> $stable(mode_q) && (cnt_q == '0));
endmodule

// File: rtl/bm_ls_gate.sv
// Module: bm_ls_gate
// Low-side drive gating: passes the request in PWM, emulates a diode in
// hysteretic mode, and never overlaps the high-side request.
// Assumes: a high-side request marks the start of each switching period.
module bm_ls_gate
    import buck_mode_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_e mode_i,
    input  logic  hs_req_i,
    input  logic  ls_req_i,
    input  logic  phase_neg_i,
    output logic  ls_drv_o
);
    logic cut_q;
    logic reverse_now;
    logic is_hys;

    // Detect reverse current during a low-side request in hysteretic mode.
    always_comb begin
        is_hys      = (mode_i == MODE_HYS);
        reverse_now = is_hys & ls_req_i & ~hs_req_i & ~phase_neg_i;
    end

    // Latch the cut until the next high-side pulse (R10).
    always_ff @(posedge clk) begin
        if (!rst_n)            cut_q <= 1'b0;
        else if (hs_req_i)     cut_q <= 1'b0;
        else if (!is_hys)      cut_q <= 1'b0;
        else if (reverse_now)  cut_q <= 1'b1;
    end

    // Form the gated low-side command (R8, R9, R10).
    always_comb begin
        ls_drv_o = ls_req_i & ~hs_req_i & (~is_hys | (phase_neg_i & ~cut_q));
    end

    // No shoot-through (R8).
    assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hs_req_i |-> !ls_drv_o);

    // PWM passes the request unchanged off the high-side pulse (R9).
    assert_pwm_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_hys && !hs_req_i) |-> (ls_drv_o == ls_req_i));

    // A cut stays until a high-side pulse (R10).
    assert_cut_sticks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (is_hys && $past(reverse_now) && !$past(hs_req_i) && !hs_req_i && $stable(mode_i)) |-> !ls_drv_o);
endmodule

// File: rtl/buck_mode_ctrl.sv
// Module: buck_mode_ctrl (top)
// Mode selector for one buck channel: qualifies off-period polarity
// samples, filters them through a run counter, and gates the low side.
// Assumes: all inputs synchronous to clk; synchronous active-low reset.
module buck_mode_ctrl #(
    parameter int RUN_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic force_pwm_i,
    input  logic smp_stb_i,
    input  logic phase_neg_i,
    input  logic hs_req_i,
    input  logic ls_req_i,
    output logic mode_hys_o,
    output logic ls_drv_o
);
    import buck_mode_pkg::*;

    logic  smp_valid;
    logic  smp_want_hys;
    mode_e mode_cur;

    bm_sample_qual u_qual (
        .force_i     (force_pwm_i),
        .stb_i       (smp_stb_i),
        .hs_req_i    (hs_req_i),
        .phase_neg_i (phase_neg_i),
        .valid_o     (smp_valid),
        .want_hys_o  (smp_want_hys)
    );

    bm_run_filter #(.RUN_LEN(RUN_LEN)) u_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .force_i    (force_pwm_i),
        .valid_i    (smp_valid),
        .want_hys_i (smp_want_hys),
        .mode_o     (mode_cur)
    );

    bm_ls_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_cur),
        .hs_req_i    (hs_req_i),
        .ls_req_i    (ls_req_i),
        .phase_neg_i (phase_neg_i),
        .ls_drv_o    (ls_drv_o)
    );

    // Publish the mode (R1, R4).
    assign mode_hys_o = (mode_cur == MODE_HYS);

    // Reset lands in PWM (R1).
    assert_reset_pwm_R1: assert property (@(posedge clk)
        !rst_n |=> !mode_hys_o);
endmodule

// File: tb/buck_mode_ctrl_tb.sv
module buck_mode_ctrl_tb;
    localparam int RUN = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic force_pwm = 1'b0, stb = 1'b0, pneg = 1'b1, hs = 1'b0, ls = 1'b0;
    logic mode_hys, ls_drv;

    int n_chk = 0;
    int n_bad = 0;

    // model state
    logic exp_mode = 1'b0;
    int   exp_cnt  = 0;
    logic exp_cut  = 1'b0;

    always #4 clk = ~clk;

    buck_mode_ctrl #(.RUN_LEN(RUN)) u_dut (
        .clk(clk), .rst_n(rst_n), .force_pwm_i(force_pwm), .smp_stb_i(stb),
        .phase_neg_i(pneg), .hs_req_i(hs), .ls_req_i(ls),
        .mode_hys_o(mode_hys), .ls_drv_o(ls_drv)
    );

    function automatic logic exp_ls(logic m, logic c, logic h, logic l, logic p);
        return l & ~h & (~m | (p & ~c));
    endfunction

    task automatic check(logic act, logic exp, string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step(logic f, logic s, logic p, logic h, logic l);
        logic nm; int nc; logic nct; logic q;
        nm = exp_mode; nc = exp_cnt;
        q = s & ~h & ~f;
        if (h || !exp_mode) nct = 1'b0;
        else if (l && !p) nct = 1'b1;
        else nct = exp_cut;
        if (f) begin nm = 1'b0; nc = 0; end
        else if (q) begin
            if ((~p) != exp_mode) begin
                if (exp_cnt == RUN - 1) begin nm = ~exp_mode; nc = 0; end
                else nc = exp_cnt + 1;
            end else nc = 0;
        end
        exp_mode = nm; exp_cnt = nc; exp_cut = nct;
    endtask

    // One clock: drive on falling edge, check, then advance the model on the rising edge.
    task automatic cyc(logic f, logic s, logic p, logic h, logic l, string tag);
        @(negedge clk);
        force_pwm = f; stb = s; pneg = p; hs = h; ls = l;
        #1;
        check(mode_hys, exp_mode, {tag, " mode"});
        check(ls_drv, exp_ls(exp_mode, exp_cut, h, l, p), {tag, " ls_drv R8/R9/R10"});
        @(posedge clk);
        model_step(f, s, p, h, l);
    endtask

    task automatic samples(int n, logic p, string tag);
        for (int i = 0; i < n; i++) begin
            cyc(1'b0, 1'b1, p, 1'b0, 1'b0, tag);
            cyc(1'b0, 1'b0, p, 1'b0, 1'b0, tag);
        end
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic bias;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        check(mode_hys, 1'b0, "R1 reset mode");

        // R5: seven HYS votes keep PWM, eighth switches
        samples(7, 1'b0, "R5 seven votes");
        check(mode_hys, 1'b0, "R5 after seven");
        samples(1, 1'b0, "R5 eighth vote");
        check(mode_hys, 1'b1, "R5 after eight");

        // R10: diode emulation cut and hold
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R10 hs pulse");
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R10 ls on");
        check(ls_drv, 1'b1, "R10 ls passes forward current");
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R10 reverse");
        check(ls_drv, 1'b0, "R10 cut now");
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R10 held");
        check(ls_drv, 1'b0, "R10 cut held");
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R8 overlap");
        check(ls_drv, 1'b0, "R8 overlap blocked");
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R10 rearmed");
        check(ls_drv, 1'b1, "R10 rearmed after hs");

        // R6/R7: broken run then full run back to PWM
        samples(6, 1'b1, "R7 six votes");
        samples(1, 1'b0, "R6 matching vote");
        samples(7, 1'b1, "R6 seven after break");
        check(mode_hys, 1'b1, "R6 still hysteretic");
        // R3: strobes during high-side are ignored
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R3 hs strobe");
        check(mode_hys, 1'b1, "R3 mode kept");
        samples(1, 1'b1, "R7 eighth vote");
        check(mode_hys, 1'b0, "R7 back to PWM");

        // R2: strap holds PWM
        samples(8, 1'b0, "R5 to hys again");
        check(mode_hys, 1'b1, "R5 hys again");
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R2 strap on");
        for (int i = 0; i < 10; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R2 strap samples");
        check(mode_hys, 1'b0, "R2 strap pwm");
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R9 pwm follow");
        check(ls_drv, 1'b1, "R9 ls follows");

        // random phase with biased runs
        bias = 1'b0;
        for (int i = 0; i < 6000; i++) begin
            logic f, s, p, h, l;
            if ($urandom % 40 == 0) bias = ~bias;
            f = ($urandom % 70 == 0);
            s = ($urandom % 3 == 0);
            h = ($urandom % 4 == 0);
            l = ($urandom % 2 == 0);
            p = ($urandom % 16 < 14) ? bias : ~bias;
            cyc(f, s, p, h, l, "R3/R4/R5/R6/R7 random");
        end

        // R1: reset mid-run returns to PWM with empty run
        samples(8, 1'b0, "R5 pre-reset");
        samples(5, 1'b1, "R7 partial");
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk);
        exp_mode = 1'b0; exp_cnt = 0; exp_cut = 1'b0;
        @(negedge clk); rst_n = 1'b1; #1;
        check(mode_hys, 1'b0, "R1 reset again");
        samples(7, 1'b0, "R1 run restarts");
        check(mode_hys, 1'b0, "R1 run empty after reset");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule